// File: doc/BRIEF.md
# Isolated Gate Command Fault Latch

This block is the command-side control logic of an isolated power-switch gate driver. It takes two command levels, one active-high and one active-low, and merges them into a single gate-on request that is passed on to the power side. The power side reports a desaturation event on a feedback line. The block brings that line into its clock domain, latches the event, forces the gate request off and pulls an active-low fault flag down for the host.

The latch clears only on an active-low clear input. The clear is honoured only after a programmable minimum number of cycles with the flag low. This minimum makes it safe to wire the flag straight back to the clear input: the block then re-arms by itself after each fault, and every flag pulse still has a guaranteed width. In normal use the host holds one command input at its idle level and toggles the other, which selects between non-inverting and inverting operation.

Top module: `gate_cmd_guard`

## Requirements
- R1: While no fault is latched, `gateReq` equals `cmdPos AND NOT cmdNeg`, combinationally. In non-inverting use `cmdNeg` is held at 0 and `gateReq` follows `cmdPos`.
- R2: In inverting use `cmdPos` is held at 1 and `gateReq` equals the complement of `cmdNeg` while no fault is latched.
- R3: `desatFb` passes through a synchroniser of `SYNC_STAGES` flops (default 2). When `clrN` is high, a high level that is first sampled on one rising edge makes `faultN` fall after the third rising edge, counting that first edge. A single-cycle pulse is enough.
- R4: While a fault is latched (`faultN` = 0), `gateReq` is 0 whatever the command inputs are.
- R5: While `clrN` stays high, a latched fault stays latched for as long as that lasts.
- R6: `faultN` stays low for at least `MIN_PULSE` cycles. If `clrN` is held low from the moment the flag falls, the latch clears on the `MIN_PULSE`-th rising edge after the edge that set it. A low `clrN` before the count expires has no effect.
- R7: While no fault is latched, `clrN` has no effect on `gateReq` or `faultN`.
- R8: A synchronised fault that is present while `clrN` is low does not set the latch. The fault is latched on the first edge after `clrN` returns high. This also applies right after a clear.
- R9: With `faultN` wired to `clrN`, a persistent fault gives repeated flag pulses, each exactly `MIN_PULSE` cycles low and one cycle high. A one-cycle fault gives exactly one pulse of `MIN_PULSE` cycles.
- R10: The asynchronous active-low `rstN` clears the latch, the timer and the synchroniser. During and after reset `faultN` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdPos | input | 1 | Active-high gate command |
| cmdNeg | input | 1 | Active-low gate command |
| clrN | input | 1 | Active-low fault clear |
| desatFb | input | 1 | Asynchronous desaturation report from power side |
| gateReq | output | 1 | Gate-on request forwarded to power side |
| faultN | output | 1 | Active-low latched fault flag |

## Verification
The merge function is driven with `cmdNeg` held low while `cmdPos` toggles, and with `cmdPos` held high while `cmdNeg` toggles. It is also driven through all four combinations of the two inputs, which separates a correct AND-NOT from a plain follower of either input. Fault handling is tried four ways:
- a single-cycle feedback pulse, with the clear held low early, which exposes an off-by-one in the minimum-width count;
- the clear held high for a long stretch, which shows that nothing but the clear releases the latch;
- a fault held during a low clear, which shows whether latching is gated by the clear;
- the auto-reset loop with a brief fault and with a persistent fault, which tells a single pulse apart from a repeating pulse train of the right width.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } guardState_e;

  typedef struct packed {
    logic setLatch;
    logic tick;
    logic clrLatch;
  } guardStrb_t;

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import gate_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncFault,
  input  logic       clrN,
  input  logic       timerZero,
  output guardStrb_t strb
);
  guardState_e state, stateNxt;

  always_comb begin
    stateNxt      = state;
    strb          = '0;
    unique case (state)
      ST_IDLE: begin
        if (syncFault && clrN) begin
          strb.setLatch = 1'b1;
          stateNxt      = ST_HOLD;
        end
      end
      ST_HOLD, ST_WAIT: begin
        if (!timerZero) begin
          strb.tick = 1'b1;
        end else if (!clrN) begin
          strb.clrLatch = 1'b1;
          stateNxt      = ST_IDLE;
        end else begin
          stateNxt      = ST_WAIT;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R3

  AST_WAIT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> timerZero); // R6
endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import gate_guard_pkg::*;
#(
  parameter int MIN_PULSE = 375
) (
  input  logic       clk,
  input  logic       rstN,
  input  guardStrb_t strb,
  input  logic       cmdPos,
  input  logic       cmdNeg,
  output logic       timerZero,
  output logic       gateReq,
  output logic       faultN
);
  localparam int CW = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE);
  localparam logic [CW-1:0] LOAD_VAL = CW'(MIN_PULSE - 1);

  logic          faultLatched;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              faultLatched <= 1'b0;
    else if (strb.setLatch) faultLatched <= 1'b1;
    else if (strb.clrLatch) faultLatched <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              holdCnt <= '0;
    else if (strb.setLatch) holdCnt <= LOAD_VAL;
    else if (strb.tick)     holdCnt <= holdCnt - 1'b1;

  assign timerZero = (holdCnt == '0);
  assign gateReq   = cmdPos & ~cmdNeg & ~faultLatched;
  assign faultN    = ~faultLatched;

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> (holdCnt == LOAD_VAL)); // R6

  AST_TICK_ONLY_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |-> faultLatched); // R6

  AST_CLR_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> $past(holdCnt) == '0); // R6
endmodule

// File: rtl/gate_cmd_guard.sv
module gate_cmd_guard
  import gate_guard_pkg::*;
#(
  parameter int MIN_PULSE   = 375,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdPos,
  input  logic cmdNeg,
  input  logic clrN,
  input  logic desatFb,
  output logic gateReq,
  output logic faultN
);
  logic       syncFault;
  logic       timerZero;
  guardStrb_t strb;

  fault_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(desatFb), .syncOut(syncFault)
  );

  guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .syncFault(syncFault), .clrN(clrN),
    .timerZero(timerZero), .strb(strb)
  );

  guard_datapath #(.MIN_PULSE(MIN_PULSE)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdPos(cmdPos), .cmdNeg(cmdNeg),
    .timerZero(timerZero), .gateReq(gateReq), .faultN(faultN)
  );

  AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> !gateReq); // R4

  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!faultN && clrN) |=> !faultN); // R5

  AST_SET_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> $past(syncFault) && $past(clrN)); // R3
endmodule

// File: tb/gate_cmd_guard_tb_top.sv
module gate_cmd_guard_tb_top;
  localparam int MP = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, cmdPos, cmdNeg, clrDrv, desatFb, autoMode;
  logic gateReq, faultN;
  wire  clrN = autoMode ? faultN : clrDrv;

  gate_cmd_guard #(.MIN_PULSE(MP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdPos(cmdPos), .cmdNeg(cmdNeg),
    .clrN(clrN), .desatFb(desatFb), .gateReq(gateReq), .faultN(faultN)
  );

  int    nCmp = 0;
  int    nBad = 0;
  string tag  = "R10";
  bit    done = 1'b0;

  // behavioural reference
  bit mS1, mS2, mLat;
  int mCnt;

  always @(posedge clk or negedge rstN) begin
    bit clrM;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mLat = 0; mCnt = 0;
    end else begin
      clrM = autoMode ? !mLat : clrDrv;
      if (!mLat) begin
        if (mS2 && clrM) begin mLat = 1; mCnt = MP - 1; end
      end else if (mCnt > 0) begin
        mCnt = mCnt - 1;
      end else if (!clrM) begin
        mLat = 0;
      end
      mS2 = mS1;
      mS1 = desatFb;
    end
  end

  always @(negedge clk) begin
    logic expGate, expFault;
    #2;
    expFault = !mLat;
    expGate  = cmdPos & !cmdNeg & !mLat;
    nCmp++;
    if (faultN !== expFault) begin
      nBad++;
      $display("FAIL %s faultN actual=%b expected=%b t=%0t", tag, faultN, expFault, $time);
    end
    nCmp++;
    if (gateReq !== expGate) begin
      nBad++;
      $display("FAIL %s gateReq actual=%b expected=%b t=%0t", tag, gateReq, expGate, $time);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 0; cmdPos = 0; cmdNeg = 0; clrDrv = 1; desatFb = 0; autoMode = 0;
    tag = "R10"; step(3);
    rstN = 1; step(2);

    tag = "R1"; cmdNeg = 0;
    for (int i = 0; i < 8; i++) begin cmdPos = (i % 3 != 0); step(1); end
    for (int i = 0; i < 4; i++) begin {cmdPos, cmdNeg} = 2'(i); step(1); end

    tag = "R2"; cmdPos = 1;
    for (int i = 0; i < 8; i++) begin cmdNeg = (i % 2 == 1); step(1); end

    tag = "R7"; cmdPos = 1; cmdNeg = 0; clrDrv = 0; step(2);
    cmdPos = 0; step(1); cmdPos = 1; step(1); clrDrv = 1; step(2);

    tag = "R3"; desatFb = 1; step(1); desatFb = 0; step(4);
    tag = "R4";
    for (int i = 0; i < 4; i++) begin {cmdPos, cmdNeg} = 2'(i); step(1); end
    cmdPos = 1; cmdNeg = 0;
    tag = "R6"; clrDrv = 0; step(MP + 4); clrDrv = 1; step(2);

    tag = "R5"; desatFb = 1; step(1); desatFb = 0;
    for (int i = 0; i < 3 * MP; i++) begin cmdPos = i[0]; step(1); end
    cmdPos = 1; clrDrv = 0; step(2); clrDrv = 1; step(2);

    tag = "R8"; desatFb = 1; clrDrv = 0; step(6);
    clrDrv = 1; step(MP + 2);
    clrDrv = 0; step(3); clrDrv = 1; step(3);
    desatFb = 0; step(MP); clrDrv = 0; step(2); clrDrv = 1; step(2);

    tag = "R9"; autoMode = 1; step(2);
    desatFb = 1; step(1); desatFb = 0; step(2 * MP);
    desatFb = 1; step(3 * MP + 5); desatFb = 0; step(2 * MP + 4);
    autoMode = 0; step(2);

    tag = "R10"; desatFb = 1; step(1); desatFb = 0; step(5);
    rstN = 0; step(2); rstN = 1; step(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule